// File: doc/BRIEF.md
# Nested zero-overhead loop controller

This block is the loop-control unit of a packet-based instruction sequencer. It holds two loop register sets, an inner loop (loop 0) and an outer loop (loop 1). Each set keeps a start address and a 32-bit unsigned iteration count. A setup command writes both values of one set in a single cycle. Separate direct writes change a single field. For every retiring packet the sequencer presents end-of-loop flags for loop 0 and loop 1. In that same cycle the block answers with a redirect request and its target PC, so a taken loop branch costs no bubble.

A pipelined setup of the inner loop also drives an automatic predicate. Software uses that predicate to suppress stores while a software pipeline is filling. The predicate is cleared at setup and turns true once the inner loop has completed a programmed number of iterations, from 1 to 3. Every piece of loop state can be read and written: both start addresses, both counts, the stage count and the predicate. An interrupt handler or a context switch can therefore save a suspended loop and later reload it, and the loop resumes correctly.

Top module: `zloop_ctrl`

## Requirements
- R1: After reset, both start addresses, both counts, the stage count and the predicate read as zero, and no redirect is issued.
- R2: A valid packet carrying the loop-N end flag, with count N greater than 1, raises redir_valid in the same cycle with redir_pc equal to start N. Count N is one lower from the next cycle on.
- R3: A loop end with a count of 0 or 1 gives no redirect and leaves the count unchanged, so the body runs exactly once.
- R4: With setup_imm=1 the loaded count is the low 10 bits of setup_count, zero-extended. With setup_imm=0 all 32 bits are loaded.
- R5: The field codes used by direct writes and read-back are: 0 start, 1 count, 2 stage count, 3 predicate. wr_sel and rd_sel pick the loop for codes 0 and 1. Read-back zero-extends narrow fields.
- R6: When one packet ends both loops, loop 0 is tested first. If count 0 is greater than 1, the branch goes to start 0 and only count 0 decrements. Otherwise loop 1 is tested in the same way in the same cycle.
- R7: A pipelined setup of loop 0 (setup_pipe=1, setup_sel=0) clears the predicate and loads the stage count. Each valid loop-0 end packet lowers a nonzero stage count by one. The predicate reads true from the cycle after the end packet that completes the programmed number of iterations. For loop 1, setup_pipe has no effect on the predicate or the stage count.
- R8: Writing previously saved start and count values back through the direct-write path resumes the loop: the next end packet branches to the restored start and decrements the restored count.
- R9: A setup command overrides a direct write and a loop-end decrement to the same loop in the same cycle. A direct count write overrides a decrement in the same cycle.
- R10: End flags on a packet with pkt_valid low cause no redirect and leave all counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | Setup command this cycle |
| setup_sel | input | 1 | Loop targeted by setup (0 inner, 1 outer) |
| setup_start | input | AW | Start address for setup |
| setup_count | input | CW | Iteration count for setup |
| setup_imm | input | 1 | Immediate form: keep only the low 10 count bits |
| setup_pipe | input | 1 | Pipelined setup (acts on loop 0 only) |
| setup_stages | input | SW | Pipeline stage count, 1 to 3 |
| wr_valid | input | 1 | Direct single-field write |
| wr_sel | input | 1 | Loop targeted by a start/count write |
| wr_field | input | 2 | Field code of the write |
| wr_data | input | CW | Write data |
| rd_sel | input | 1 | Loop selected for read-back |
| rd_field | input | 2 | Field code of the read-back |
| rd_data | output | CW | Read-back data |
| pkt_valid | input | 1 | A packet retires this cycle |
| pkt_end0 | input | 1 | Packet ends loop 0 |
| pkt_end1 | input | 1 | Packet ends loop 1 |
| redir_valid | output | 1 | Loop branch taken this cycle |
| redir_pc | output | AW | Branch target |
| pipe_pred | output | 1 | Automatic pipeline predicate |

## Verification
The properties assume that stage counts given with a pipelined setup lie between 1 and 3, and that the address width is no wider than the count width. They also assume that any count decrement a property predicts happens in a cycle with no setup or direct write, because those override it. The stimulus drives every command through one task at the falling edge. It uses stage values only from the legal range, and it brings setup, write and end packets together only in the cycles that deliberately test the override order.

// File: rtl/zloop_pkg.sv
package zloop_pkg;
  typedef enum logic [1:0] {
    FLD_START = 2'd0,
    FLD_COUNT = 2'd1,
    FLD_STAGE = 2'd2,
    FLD_PRED  = 2'd3
  } loop_fld_e;

  localparam int unsigned NUM_LOOPS = 2;
endpackage

// File: rtl/zloop_bank.sv
module zloop_bank #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_start,
  input  logic [CW-1:0] set_count,
  input  logic          wr_start_en,
  input  logic          wr_count_en,
  input  logic [CW-1:0] wr_data,
  input  logic          dec_en,
  output logic [AW-1:0] start_q,
  output logic [CW-1:0] count_q
);
  logic [AW-1:0] start_d;
  logic [CW-1:0] count_d;
  logic          start_ld;
  logic          count_ld;

  // priority: setup, then direct write, then decrement
  always_comb begin
    start_d = start_q;
    if (set_en)           start_d = set_start;
    else if (wr_start_en) start_d = wr_data[AW-1:0];
  end

  always_comb begin
    count_d = count_q;
    if (set_en)           count_d = set_count;
    else if (wr_count_en) count_d = wr_data;
    else if (dec_en)      count_d = count_q - CW'(1);
  end

  assign start_ld = set_en | wr_start_en;
  assign count_ld = set_en | wr_count_en | dec_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (start_ld) begin
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_ld) begin
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/zloop_resolve.sv
module zloop_resolve #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input  logic          pkt_valid,
  input  logic          end0,
  input  logic          end1,
  input  logic [CW-1:0] cnt0,
  input  logic [CW-1:0] cnt1,
  input  logic [AW-1:0] sa0,
  input  logic [AW-1:0] sa1,
  output logic          take0,
  output logic          take1,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc
);
  logic more0;
  logic more1;

  assign more0 = (cnt0 > CW'(1));
  assign more1 = (cnt1 > CW'(1));

  // inner loop has precedence on a shared end packet
  always_comb begin
    take0 = pkt_valid & end0 & more0;
    take1 = pkt_valid & end1 & more1 & ~take0;
    redir_valid = take0 | take1;
    redir_pc = '0;
    if (take0)      redir_pc = sa0;
    else if (take1) redir_pc = sa1;
  end
endmodule

// File: rtl/zloop_pstage.sv
module zloop_pstage #(
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [SW-1:0] arm_stages,
  input  logic          iter_done,
  input  logic          wr_stage_en,
  input  logic [SW-1:0] wr_stage,
  input  logic          wr_pred_en,
  input  logic          wr_pred,
  output logic [SW-1:0] stage_q,
  output logic          pred_q
);
  logic [SW-1:0] stage_d;
  logic          pred_d;
  logic          upd_en;

  always_comb begin
    stage_d = stage_q;
    pred_d  = pred_q;
    if (arm) begin
      stage_d = arm_stages;
      pred_d  = 1'b0;
    end else begin
      if (wr_stage_en) begin
        stage_d = wr_stage;
      end else if (iter_done && (stage_q != '0)) begin
        stage_d = stage_q - SW'(1);
        if (stage_q == SW'(1)) pred_d = 1'b1;
      end
      if (wr_pred_en) pred_d = wr_pred;
    end
  end

  assign upd_en = arm | wr_stage_en | wr_pred_en | iter_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pred_q  <= 1'b0;
    end else if (upd_en) begin
      stage_q <= stage_d;
      pred_q  <= pred_d;
    end
  end
endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl #(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 32,
  parameter int unsigned SW   = 2,
  parameter int unsigned IMMW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_valid,
  input  logic          setup_sel,
  input  logic [AW-1:0] setup_start,
  input  logic [CW-1:0] setup_count,
  input  logic          setup_imm,
  input  logic          setup_pipe,
  input  logic [SW-1:0] setup_stages,
  input  logic          wr_valid,
  input  logic          wr_sel,
  input  logic [1:0]    wr_field,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  input  logic [1:0]    rd_field,
  output logic [CW-1:0] rd_data,
  input  logic          pkt_valid,
  input  logic          pkt_end0,
  input  logic          pkt_end1,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc,
  output logic          pipe_pred
);
  import zloop_pkg::*;

  localparam int unsigned NL = NUM_LOOPS;

  logic [CW-1:0] setup_cnt_eff;
  logic [AW-1:0] sa_q [NL];
  logic [CW-1:0] lc_q [NL];
  logic [NL-1:0] take;
  logic [SW-1:0] stage_q;
  logic          pred_q;
  logic          arm;
  logic          iter_done;
  logic          wr_stage_en;
  logic          wr_pred_en;

  assign setup_cnt_eff = setup_imm ? CW'(setup_count[IMMW-1:0]) : setup_count;

  for (genvar g = 0; g < NL; g++) begin : g_bank
    localparam logic SELV = 1'(g);
    logic set_en;
    logic wst_en;
    logic wct_en;
    assign set_en = setup_valid & (setup_sel == SELV);
    assign wst_en = wr_valid & (wr_sel == SELV) & (wr_field == FLD_START);
    assign wct_en = wr_valid & (wr_sel == SELV) & (wr_field == FLD_COUNT);
    zloop_bank #(.AW(AW), .CW(CW)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_en      (set_en),
      .set_start   (setup_start),
      .set_count   (setup_cnt_eff),
      .wr_start_en (wst_en),
      .wr_count_en (wct_en),
      .wr_data     (wr_data),
      .dec_en      (take[g]),
      .start_q     (sa_q[g]),
      .count_q     (lc_q[g])
    );
  end

  zloop_resolve #(.AW(AW), .CW(CW)) u_resolve (
    .pkt_valid   (pkt_valid),
    .end0        (pkt_end0),
    .end1        (pkt_end1),
    .cnt0        (lc_q[0]),
    .cnt1        (lc_q[1]),
    .sa0         (sa_q[0]),
    .sa1         (sa_q[1]),
    .take0       (take[0]),
    .take1       (take[1]),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc)
  );

  assign arm         = setup_valid & setup_pipe & ~setup_sel;
  assign iter_done   = pkt_valid & pkt_end0;
  assign wr_stage_en = wr_valid & (wr_field == FLD_STAGE);
  assign wr_pred_en  = wr_valid & (wr_field == FLD_PRED);

  zloop_pstage #(.SW(SW)) u_pstage (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .arm_stages  (setup_stages),
    .iter_done   (iter_done),
    .wr_stage_en (wr_stage_en),
    .wr_stage    (wr_data[SW-1:0]),
    .wr_pred_en  (wr_pred_en),
    .wr_pred     (wr_data[0]),
    .stage_q     (stage_q),
    .pred_q      (pred_q)
  );

  assign pipe_pred = pred_q;

  always_comb begin
    unique case (rd_field)
      FLD_START: rd_data = CW'(sa_q[rd_sel]);
      FLD_COUNT: rd_data = lc_q[rd_sel];
      FLD_STAGE: rd_data = CW'(stage_q);
      default:   rd_data = CW'(pred_q);
    endcase
  end
endmodule

// File: rtl/zloop_ctrl_chk.sv
module zloop_ctrl_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          setup_valid,
  input logic          setup_sel,
  input logic          setup_imm,
  input logic          setup_pipe,
  input logic [CW-1:0] setup_count,
  input logic          wr_valid,
  input logic          pkt_valid,
  input logic          pkt_end0,
  input logic          pkt_end1,
  input logic          redir_valid,
  input logic [AW-1:0] redir_pc,
  input logic          pipe_pred,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic [AW-1:0] sa0
);
  AST_REDIR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (pkt_valid && (pkt_end0 || pkt_end1))); // R2

  AST_DEC_INNER: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_end0 && (cnt0 > CW'(1)) && !setup_valid && !wr_valid)
      |=> (cnt0 == $past(cnt0) - CW'(1))); // R2

  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_end0 && !pkt_end1 && (cnt0 <= CW'(1))) |-> !redir_valid); // R3

  AST_INNER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_end0 && pkt_end1 && (cnt0 > CW'(1)))
      |-> (redir_valid && (redir_pc == sa0))); // R6

  AST_OUTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_end0 && pkt_end1 && (cnt0 > CW'(1)) && !setup_valid && !wr_valid)
      |=> $stable(cnt1)); // R6

  AST_PRED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && setup_pipe && !setup_sel) |=> !pipe_pred); // R7

  AST_SETUP_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_valid && !setup_sel && !setup_imm) |=> (cnt0 == $past(setup_count))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !redir_valid); // R10
endmodule

bind zloop_ctrl zloop_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_valid (setup_valid),
  .setup_sel   (setup_sel),
  .setup_imm   (setup_imm),
  .setup_pipe  (setup_pipe),
  .setup_count (setup_count),
  .wr_valid    (wr_valid),
  .pkt_valid   (pkt_valid),
  .pkt_end0    (pkt_end0),
  .pkt_end1    (pkt_end1),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .pipe_pred   (pipe_pred),
  .cnt0        (lc_q[0]),
  .cnt1        (lc_q[1]),
  .sa0         (sa_q[0])
);

// File: tb/zloop_ctrl_test.sv
module zloop_ctrl_test;
  localparam int CLK_PER = 10;

  logic        clk;
  logic        rst_n;
  logic        setup_valid, setup_sel, setup_imm, setup_pipe;
  logic [31:0] setup_start, setup_count;
  logic [1:0]  setup_stages;
  logic        wr_valid, wr_sel;
  logic [1:0]  wr_field;
  logic [31:0] wr_data;
  logic        rd_sel;
  logic [1:0]  rd_field;
  logic [31:0] rd_data;
  logic        pkt_valid, pkt_end0, pkt_end1;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        pipe_pred;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic        v;
    logic [31:0] pc;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  zloop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_sel(setup_sel), .setup_start(setup_start),
    .setup_count(setup_count), .setup_imm(setup_imm), .setup_pipe(setup_pipe),
    .setup_stages(setup_stages),
    .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_field(wr_field), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_field(rd_field), .rd_data(rd_data),
    .pkt_valid(pkt_valid), .pkt_end0(pkt_end0), .pkt_end1(pkt_end1),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .pipe_pred(pipe_pred)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus, driven at the falling edge, expectation queued
  task automatic step(input logic sv, input logic ssel, input logic [31:0] sst,
                      input logic [31:0] scnt, input logic simm, input logic spipe,
                      input logic [1:0] sstg, input logic wv, input logic wsel,
                      input logic [1:0] wf, input logic [31:0] wd, input logic pv,
                      input logic e0, input logic e1, input logic xv,
                      input logic [31:0] xpc, input string tag);
    @(negedge clk);
    setup_valid = sv; setup_sel = ssel; setup_start = sst; setup_count = scnt;
    setup_imm = simm; setup_pipe = spipe; setup_stages = sstg;
    wr_valid = wv; wr_sel = wsel; wr_field = wf; wr_data = wd;
    pkt_valid = pv; pkt_end0 = e0; pkt_end1 = e1;
    exp_q.push_back('{xv, xpc, tag});
  endtask

  task automatic setup(input logic sel, input logic [31:0] st, input logic [31:0] cnt,
                       input logic imm, input logic pipe, input logic [1:0] stg);
    step(1, sel, st, cnt, imm, pipe, stg, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic wr(input logic sel, input logic [1:0] f, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 0, 1, sel, f, d, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic pkt(input logic pv, input logic e0, input logic e1,
                     input logic xv, input logic [31:0] xpc, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, pv, e0, e1, xv, xpc, tag);
  endtask

  task automatic rd_chk(input logic sel, input logic [1:0] f, input logic [31:0] exp, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rd_sel = sel; rd_field = f;
    #(CLK_PER/4);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic pred_chk(input logic exp, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    #(CLK_PER/4);
    chk(pipe_pred == exp, tag, 32'(pipe_pred), 32'(exp));
  endtask

  // monitor: compares the redirect outputs against the queued expectation
  always begin
    @(negedge clk);
    #(CLK_PER/4);
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk((redir_valid == e.v) && (!e.v || redir_pc == e.pc),
          $sformatf("%s redirect valid=%0b/%0b", e.tag, redir_valid, e.v), redir_pc, e.pc);
    end
  end

  initial begin
    #(CLK_PER * 50000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    setup_valid = 0; setup_sel = 0; setup_start = 0; setup_count = 0;
    setup_imm = 0; setup_pipe = 0; setup_stages = 0;
    wr_valid = 0; wr_sel = 0; wr_field = 0; wr_data = 0;
    rd_sel = 0; rd_field = 0;
    pkt_valid = 0; pkt_end0 = 0; pkt_end1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(0, 0, 32'h0, "R1 start0");
    rd_chk(1, 0, 32'h0, "R1 start1");
    rd_chk(0, 1, 32'h0, "R1 count0");
    rd_chk(1, 1, 32'h0, "R1 count1");
    rd_chk(0, 2, 32'h0, "R1 stage");
    pred_chk(0, "R1 pred");
    pkt(0, 0, 0, 0, 0, "R1");

    // R2 / R3 basic loop of three
    setup(0, 32'h100, 32'd3, 0, 0, 0);
    pkt(1, 1, 0, 1, 32'h100, "R2");
    rd_chk(0, 1, 32'd2, "R2 count after branch");
    pkt(1, 1, 0, 1, 32'h100, "R2");
    pkt(1, 1, 0, 0, 0, "R3");
    rd_chk(0, 1, 32'd1, "R3 count held");
    rd_chk(0, 0, 32'h100, "R5 start0 readback");

    // R4 immediate and register count forms
    setup(0, 32'h110, 32'h0001_2345, 1, 0, 0);
    rd_chk(0, 1, 32'h345, "R4 immediate count");
    setup(0, 32'h110, 32'hFFFF_FFFF, 0, 0, 0);
    rd_chk(0, 1, 32'hFFFF_FFFF, "R4 register count");
    pkt(1, 1, 0, 1, 32'h110, "R2");
    rd_chk(0, 1, 32'hFFFF_FFFE, "R2 count wide");

    // R3 zero count still single pass
    setup(0, 32'h120, 32'd0, 0, 0, 0);
    pkt(1, 1, 0, 0, 0, "R3");
    rd_chk(0, 1, 32'd0, "R3 zero count held");

    // R6 shared end packet
    setup(1, 32'h200, 32'd2, 0, 0, 0);
    setup(0, 32'h300, 32'd2, 0, 0, 0);
    pkt(1, 1, 1, 1, 32'h300, "R6");
    rd_chk(0, 1, 32'd1, "R6 count0");
    rd_chk(1, 1, 32'd2, "R6 count1 held");
    pkt(1, 1, 1, 1, 32'h200, "R6");
    rd_chk(1, 1, 32'd1, "R6 count1 dec");
    rd_chk(0, 1, 32'd1, "R6 count0 held");
    pkt(1, 1, 1, 0, 0, "R6");

    // R10 invalid packet
    setup(0, 32'h310, 32'd5, 0, 0, 0);
    pkt(0, 1, 1, 0, 0, "R10");
    rd_chk(0, 1, 32'd5, "R10 count unchanged");

    // R5 / R7 predicate
    wr(0, 2'd3, 32'd1);
    pred_chk(1, "R5 pred write");
    setup(0, 32'h400, 32'd5, 0, 1, 2'd2);
    pred_chk(0, "R7 pred cleared");
    rd_chk(0, 2, 32'd2, "R7 stage loaded");
    pkt(1, 1, 0, 1, 32'h400, "R2");
    pred_chk(0, "R7 pred after one");
    rd_chk(0, 2, 32'd1, "R7 stage dec");
    pkt(1, 1, 0, 1, 32'h400, "R2");
    pred_chk(1, "R7 pred after two");
    setup(1, 32'h500, 32'd3, 0, 1, 2'd3);
    pred_chk(1, "R7 loop1 pipe ignored pred");
    rd_chk(0, 2, 32'd0, "R7 loop1 pipe ignored stage");
    wr(0, 2'd2, 32'd3);
    rd_chk(1, 2, 32'd3, "R5 stage write");
    wr(1, 2'd0, 32'hABC);
    rd_chk(1, 0, 32'hABC, "R5 start1 write");

    // R8 save and restore
    rd_chk(0, 1, 32'd3, "R8 saved count");
    rd_chk(0, 0, 32'h400, "R8 saved start");
    setup(0, 32'h700, 32'd9, 0, 0, 0);
    wr(0, 2'd0, 32'h400);
    wr(0, 2'd1, 32'd3);
    pkt(1, 1, 0, 1, 32'h400, "R8");
    rd_chk(0, 1, 32'd2, "R8 resumed count");

    // R9 override order
    step(1, 0, 32'h800, 32'd6, 0, 0, 0, 1, 0, 2'd1, 32'h55, 1, 1, 0, 1, 32'h400, "R9");
    rd_chk(0, 1, 32'd6, "R9 setup beats write and dec");
    rd_chk(0, 0, 32'h800, "R9 setup start");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 2'd1, 32'h44, 1, 1, 0, 1, 32'h800, "R9");
    rd_chk(0, 1, 32'h44, "R9 write beats dec");

    pkt(0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    #(CLK_PER/2);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule